// File: doc/BRIEF.md
# Framed Serial Sample Streamer

The streamer turns a flow of two-bit I and Q converter samples into a framed serial bit stream for a downstream signal processor. One serial bit leaves per clock cycle. A qualifier output marks every cycle that carries a valid bit, so it serves as the bit clock. Alongside the data the block drives three pulse outputs:

- a frame-start pulse;
- a pulse at the start of each 16-bit data word;
- a time-reference pulse.

Configuration arrives as static register fields on plain inputs: a master enable, start, stop and counter-clear commands (all acting on rising edges), a frame-length code, a sample-width code, and enables for the frame stamp, the word pulse and the free-running time pulse.

Each frame optionally begins with a 16-bit frame number, most significant bit first. The sample bits follow. The number of sample bits per frame is 128 shifted left by the length code. The width code selects which of the four sample bits are sent for each sample, and in what order.

Top module: `frame_streamer`

## Requirements
- R1: While `en_i` is 0 every output stays low and a start command has no effect.
- R2: A rising edge of `start_i` sampled at clock edge E puts frame bit 0 on the outputs after edge E+1. A rising edge of `stop_i` sampled at edge E drives every stream output low from edge E onward. If both rise together, stop wins.
- R3: A frame carries 128 << `flen_code_i` sample bits, plus 16 stamp bits when `stamp_en_i` is 1. After the last bit, the next cycle carries bit 0 of the next frame.
- R4: `width_i` (the bit order is the order on the wire) selects the bits sent per sample: 0 sends I sign; 1 sends I sign, I magnitude; 2 sends I sign, Q sign; 3 sends I sign, I magnitude, Q sign, Q magnitude. The sample is captured on its first bit.
- R5: With `stamp_en_i` = 1 the first 16 bits of each frame are the frame number, MSB first. With `stamp_en_i` = 0 the first bit is sample data.
- R6: The frame number is 0 after reset and increments by one, wrapping, after each complete frame.
- R7: `fsync_o` is high for exactly the one cycle that carries frame bit 0.
- R8: With `dsync_en_i` = 1, `dsync_o` is high on sample-data bits 0, 16, 32, ... counted from the first bit after the stamp. It is never high during the stamp, and it is always low when `dsync_en_i` is 0.
- R9: `tsync_o` pulses for one cycle at bit 0 of every frame. With `tsync_all_i` = 1 and `en_i` = 1, frame timing and the frame number keep running while stopped: `tsync_o` still pulses and all other outputs stay low. With `tsync_all_i` = 0, `tsync_o` stays low while stopped.
- R10: A rising edge of `crst_i` clears the bit position and the frame number. One idle cycle follows, then a frame numbered 0 begins.
- R11: A stop in mid-frame takes effect at once. The next start begins at bit 0 and keeps the frame number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one serial bit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Master stream enable |
| start_i | input | 1 | Start command, rising edge |
| stop_i | input | 1 | Stop command, rising edge |
| crst_i | input | 1 | Counter-clear command, rising edge |
| flen_code_i | input | 3 | Frame length code, 128 << code data bits |
| width_i | input | 2 | Bits-per-sample code |
| stamp_en_i | input | 1 | Insert frame number at frame start |
| tsync_all_i | input | 1 | Time pulse whenever enabled (1) or only while streaming (0) |
| dsync_en_i | input | 1 | Enable data-word pulse |
| i_sign_i | input | 1 | I sample sign bit |
| i_mag_i | input | 1 | I sample magnitude bit |
| q_sign_i | input | 1 | Q sample sign bit |
| q_mag_i | input | 1 | Q sample magnitude bit |
| bclk_en_o | output | 1 | Bit qualifier, high on cycles carrying a bit |
| sdata_o | output | 1 | Serial data |
| fsync_o | output | 1 | Frame-start pulse |
| dsync_o | output | 1 | Data-word start pulse |
| tsync_o | output | 1 | Time-reference pulse |

## Verification
Every width code is driven with a held sample chosen so that a wrong selection or a swapped order produces a visibly different bit: a pattern of 1001 for the full mode, 0110 for the I pair, 1011 for I/Q sign and 0111 for the single bit. Frames are run at the shortest and the second length code, with and without the stamp, so that stamp offset, frame wrap and frame-number increments are compared bit by bit across frame boundaries. Stops are placed in mid-frame, and the restart shows whether the position was cleared and the number kept. The free-running time mode is exercised while stopped, which separates continuous frame timing from gated timing. The counter clear is issued mid-stream with stamping on, so the number returning to zero is visible on the wire.

// File: rtl/fss_pkg.sv
// Shared types for the framed serial streamer.
package fss_pkg;

    // Bits-per-sample selection; the numeric values are the register codes.
    typedef enum logic [1:0] {
        W_ISGN  = 2'd0,
        W_IPAIR = 2'd1,
        W_IQSGN = 2'd2,
        W_FULL  = 2'd3
    } wmode_t;

    // One converter sample: sign and magnitude for each rail.
    typedef struct packed {
        logic i_sgn;
        logic i_mag;
        logic q_sgn;
        logic q_mag;
    } sample_t;

endpackage

// File: rtl/fss_cmd.sv
// Command unit: rising-edge detection of start, stop and counter-clear,
// and the streaming state. Assumes the command inputs are synchronous to clk.
// Outputs whether frame timing runs this cycle and whether the position
// must restart instead of advancing.
module fss_cmd (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic start_i,
    input  logic stop_i,
    input  logic crst_i,
    input  logic tsync_all_i,
    output logic active_o,
    output logic run_o,
    output logic restart_o,
    output logic zero_o
);
    logic start_q, stop_q, crst_q, active_q;
    logic start_pe, stop_pe, crst_pe;

    assign start_pe = start_i & ~start_q;
    assign stop_pe  = stop_i  & ~stop_q;
    assign crst_pe  = crst_i  & ~crst_q;

    // Track previous command levels and the streaming state (stop wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q  <= 1'b0;
            stop_q   <= 1'b0;
            crst_q   <= 1'b0;
            active_q <= 1'b0;
        end else begin
            start_q <= start_i;
            stop_q  <= stop_i;
            crst_q  <= crst_i;
            if (!en_i || stop_pe)
                active_q <= 1'b0;
            else if (start_pe)
                active_q <= 1'b1;
        end
    end

    assign active_o  = active_q;
    assign run_o     = en_i & (active_q | tsync_all_i);
    assign restart_o = start_pe | stop_pe | crst_pe | ~en_i;
    assign zero_o    = crst_pe;
endmodule

// File: rtl/fss_count.sv
// Frame position and frame number counters. The position walks from 0 to
// the last bit of the frame (stamp plus data) and wraps, bumping the
// frame number. Assumes the length code is stable within a frame.
module fss_count #(
    parameter int BASE_LEN = 128,
    parameter int CODE_W   = 3,
    parameter int STAMP_W  = 16,
    parameter int POS_W    = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic               restart_i,
    input  logic               zero_i,
    input  logic               stamp_en_i,
    input  logic [CODE_W-1:0]  flen_code_i,
    output logic [POS_W-1:0]   pos_o,
    output logic [STAMP_W-1:0] fnum_o
);
    logic [POS_W-1:0]   pos_q;
    logic [STAMP_W-1:0] fnum_q;
    logic [POS_W-1:0]   data_len;
    logic [POS_W-1:0]   frame_last;

    // Last position of the current frame.
    always_comb begin
        data_len   = POS_W'(BASE_LEN) << flen_code_i;
        frame_last = data_len + (stamp_en_i ? POS_W'(STAMP_W) : '0) - POS_W'(1);
    end

    // Advance position, wrap at frame end and count frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q  <= '0;
            fnum_q <= '0;
        end else if (zero_i) begin
            pos_q  <= '0;
            fnum_q <= '0;
        end else if (restart_i) begin
            pos_q  <= '0;
        end else if (run_i) begin
            if (pos_q >= frame_last) begin
                pos_q  <= '0;
                fnum_q <= fnum_q + STAMP_W'(1);
            end else begin
                pos_q  <= pos_q + POS_W'(1);
            end
        end
    end

    assign pos_o  = pos_q;
    assign fnum_o = fnum_q;
endmodule

// File: rtl/fss_shift.sv
// Serializer: picks the bit for the current frame position (stamp bit or
// sample bit), captures the sample on its first bit and registers the
// serial data and the three pulse outputs.
module fss_shift
    import fss_pkg::*;
#(
    parameter int STAMP_W = 16,
    parameter int WORD_W  = 16,
    parameter int POS_W   = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               emit_i,
    input  logic               active_i,
    input  logic [POS_W-1:0]   pos_i,
    input  logic [STAMP_W-1:0] fnum_i,
    input  logic               stamp_en_i,
    input  wmode_t             width_i,
    input  logic               dsync_en_i,
    input  sample_t            smp_i,
    output logic               bclk_en_o,
    output logic               sdata_o,
    output logic               fsync_o,
    output logic               dsync_o,
    output logic               tsync_o
);
    localparam int SIX_W = $clog2(STAMP_W);
    localparam logic [POS_W-1:0] STAMP_P = POS_W'(STAMP_W);

    sample_t          held_q, cur;
    logic             in_stamp, frame_head, word_head, bit_val, stamp_bit, smp_bit;
    logic [POS_W-1:0] dpos;
    logic [1:0]       slot;
    logic [SIX_W-1:0] sidx;

    // Decode the position into stamp/data, sample slot and word start.
    always_comb begin
        in_stamp   = stamp_en_i && (pos_i < STAMP_P);
        dpos       = pos_i - (stamp_en_i ? STAMP_P : '0);
        frame_head = (pos_i == '0);
        word_head  = ((dpos & POS_W'(WORD_W - 1)) == '0);
        unique case (width_i)
            W_ISGN:           slot = 2'd0;
            W_IPAIR, W_IQSGN: slot = {1'b0, dpos[0]};
            default:          slot = dpos[1:0];
        endcase
        sidx      = SIX_W'(STAMP_W - 1) - pos_i[SIX_W-1:0];
        stamp_bit = fnum_i[sidx];
    end

    // Select the sample bit; slot 0 uses the live sample.
    always_comb begin
        cur = (slot == 2'd0) ? smp_i : held_q;
        unique case (width_i)
            W_ISGN:  smp_bit = cur.i_sgn;
            W_IPAIR: smp_bit = slot[0] ? cur.i_mag : cur.i_sgn;
            W_IQSGN: smp_bit = slot[0] ? cur.q_sgn : cur.i_sgn;
            default: begin
                unique case (slot)
                    2'd0:    smp_bit = cur.i_sgn;
                    2'd1:    smp_bit = cur.i_mag;
                    2'd2:    smp_bit = cur.q_sgn;
                    default: smp_bit = cur.q_mag;
                endcase
            end
        endcase
        bit_val = in_stamp ? stamp_bit : smp_bit;
    end

    // Hold the sample captured on its first bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_q <= '0;
        else if (emit_i && !in_stamp && slot == 2'd0)
            held_q <= smp_i;
    end

    // Register the stream outputs.
    always_ff @(posedge clk) begin
        if (!rst_n || !emit_i) begin
            bclk_en_o <= 1'b0;
            sdata_o   <= 1'b0;
            fsync_o   <= 1'b0;
            dsync_o   <= 1'b0;
            tsync_o   <= 1'b0;
        end else begin
            bclk_en_o <= active_i;
            sdata_o   <= active_i & bit_val;
            fsync_o   <= active_i & frame_head;
            dsync_o   <= active_i & dsync_en_i & ~in_stamp & word_head;
            tsync_o   <= frame_head;
        end
    end
endmodule

// File: rtl/frame_streamer.sv
// Top of the framed serial streamer. Assumes all inputs are synchronous to
// clk and that configuration fields change only while stopped.
module frame_streamer
    import fss_pkg::*;
#(
    parameter int BASE_LEN = 128,
    parameter int CODE_W   = 3,
    parameter int STAMP_W  = 16,
    parameter int WORD_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              crst_i,
    input  logic [CODE_W-1:0] flen_code_i,
    input  logic [1:0]        width_i,
    input  logic              stamp_en_i,
    input  logic              tsync_all_i,
    input  logic              dsync_en_i,
    input  logic              i_sign_i,
    input  logic              i_mag_i,
    input  logic              q_sign_i,
    input  logic              q_mag_i,
    output logic              bclk_en_o,
    output logic              sdata_o,
    output logic              fsync_o,
    output logic              dsync_o,
    output logic              tsync_o
);
    localparam int FLEN_MAX = BASE_LEN << ((1 << CODE_W) - 1);
    localparam int POS_W    = $clog2(STAMP_W + FLEN_MAX + 1);

    logic               active, run, restart, zero, emit;
    logic [POS_W-1:0]   pos;
    logic [STAMP_W-1:0] fnum;
    sample_t            smp;

    assign smp  = '{i_sgn: i_sign_i, i_mag: i_mag_i, q_sgn: q_sign_i, q_mag: q_mag_i};
    assign emit = run & ~restart;

    fss_cmd u_cmd (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .start_i(start_i),
        .stop_i(stop_i), .crst_i(crst_i), .tsync_all_i(tsync_all_i),
        .active_o(active), .run_o(run), .restart_o(restart), .zero_o(zero)
    );

    fss_count #(.BASE_LEN(BASE_LEN), .CODE_W(CODE_W), .STAMP_W(STAMP_W), .POS_W(POS_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run_i(run), .restart_i(restart),
        .zero_i(zero), .stamp_en_i(stamp_en_i), .flen_code_i(flen_code_i),
        .pos_o(pos), .fnum_o(fnum)
    );

    fss_shift #(.STAMP_W(STAMP_W), .WORD_W(WORD_W), .POS_W(POS_W)) u_shf (
        .clk(clk), .rst_n(rst_n), .emit_i(emit), .active_i(active),
        .pos_i(pos), .fnum_i(fnum), .stamp_en_i(stamp_en_i),
        .width_i(wmode_t'(width_i)), .dsync_en_i(dsync_en_i), .smp_i(smp),
        .bclk_en_o(bclk_en_o), .sdata_o(sdata_o), .fsync_o(fsync_o),
        .dsync_o(dsync_o), .tsync_o(tsync_o)
    );
endmodule

// File: rtl/frame_streamer_chk.sv
// Protocol checker for the framed serial streamer, bound to the top.
module frame_streamer_chk (
    input logic clk,
    input logic rst_n,
    input logic en_i,
    input logic stop_i,
    input logic dsync_en_i,
    input logic bclk_en_o,
    input logic fsync_o,
    input logic dsync_o,
    input logic tsync_o
);
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_i) |-> !bclk_en_o && !tsync_o);                       // R1
    AST_STOP_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !$past(stop_i)) |=> !bclk_en_o && !fsync_o);          // R2
    AST_FSYNC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fsync_o |=> !fsync_o);                                           // R7
    AST_FSYNC_WITH_TSYNC: assert property (@(posedge clk) disable iff (!rst_n)
        fsync_o |-> tsync_o && bclk_en_o);                               // R9
    AST_DSYNC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(dsync_en_i) |-> !dsync_o);                                // R8
    AST_DSYNC_IN_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        dsync_o |-> bclk_en_o);                                          // R8
endmodule

bind frame_streamer frame_streamer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .stop_i(stop_i),
    .dsync_en_i(dsync_en_i), .bclk_en_o(bclk_en_o), .fsync_o(fsync_o),
    .dsync_o(dsync_o), .tsync_o(tsync_o)
);

// File: tb/sim_frame_streamer.sv
module sim_frame_streamer;
    logic clk = 1'b0, rst_n = 1'b0;
    logic en = 0, start = 0, stop = 0, crst = 0;
    logic [2:0] fcode = 0;
    logic [1:0] wcode = 0;
    logic stamp = 0, tsall = 0, dsen = 0;
    logic [3:0] smp = 4'b0;   // {I sign, I mag, Q sign, Q mag}
    logic bclk, sdata, fsync, dsync, tsync;

    int n_chk = 0, n_bad = 0;
    int bpos = 0, bfnum = 0;
    bit act = 0;

    always #10 clk = ~clk;   // 50 MHz

    frame_streamer u0 (
        .clk(clk), .rst_n(rst_n), .en_i(en), .start_i(start), .stop_i(stop),
        .crst_i(crst), .flen_code_i(fcode), .width_i(wcode), .stamp_en_i(stamp),
        .tsync_all_i(tsall), .dsync_en_i(dsen), .i_sign_i(smp[3]), .i_mag_i(smp[2]),
        .q_sign_i(smp[1]), .q_mag_i(smp[0]), .bclk_en_o(bclk), .sdata_o(sdata),
        .fsync_o(fsync), .dsync_o(dsync), .tsync_o(tsync)
    );

    function automatic int frame_len();
        return (128 << fcode) + (stamp ? 16 : 0);
    endfunction

    // Expected {bclk, sdata, fsync, dsync, tsync} for position p, frame number fn.
    function automatic logic [4:0] expv(int p, int fn);
        logic [15:0] f = fn[15:0];
        int d = p - (stamp ? 16 : 0);
        logic b, ds;
        bit st = stamp && (p < 16);
        if (!(en && (act || tsall))) return 5'b0;
        if (!act) return {4'b0, p == 0};
        if (st) b = f[15 - p];
        else begin
            case (wcode)
                2'd0: b = smp[3];
                2'd1: b = (d % 2) ? smp[2] : smp[3];
                2'd2: b = (d % 2) ? smp[1] : smp[3];
                default: b = smp[3 - (d % 4)];
            endcase
        end
        ds = dsen && !st && (d % 16 == 0);
        return {1'b1, b, p == 0, ds, p == 0};
    endfunction

    task automatic check(string tag, logic [4:0] got, logic [4:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b (pos %0d frame %0d)", tag, got, exp, bpos, bfnum);
        end
    endtask

    // Check n consecutive bit cycles against the model, advancing it.
    task automatic run_bits(int n, string tag);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
            check(tag, {bclk, sdata, fsync, dsync, tsync}, expv(bpos, bfnum));
            if (en && (act || tsall)) begin
                if (bpos >= frame_len() - 1) begin
                    bpos = 0;
                    bfnum = (bfnum + 1) % 65536;
                end else bpos++;
            end
        end
    endtask

    task automatic do_start();
        start = 1; @(posedge clk); #1 start = 0;
        act = en; bpos = 0;
    endtask

    task automatic do_stop(string tag);
        stop = 1; @(posedge clk); #1 stop = 0;
        act = 0; bpos = 0;
        @(negedge clk);
        check(tag, {bclk, sdata, fsync, dsync, tsync}, 5'b0);
    endtask

    task automatic t_reset();
        check("R1 reset", {bclk, sdata, fsync, dsync, tsync}, 5'b0);
    endtask

    task automatic t_disabled();
        en = 0; do_start();
        run_bits(20, "R1 disabled");
    endtask

    task automatic t_full_stamp();
        en = 1; fcode = 0; wcode = 3; stamp = 1; dsen = 1; smp = 4'b1001;
        do_start();
        run_bits(2 * 144 + 20, "R2/R3/R4/R5/R6/R7/R8");
    endtask

    task automatic t_stop_resume();
        do_stop("R11 stop at once");
        run_bits(30, "R9 quiet while stopped");
        do_start();
        run_bits(144 + 5, "R11 resume keeps frame number");
    endtask

    task automatic t_ipair_long();
        do_stop("R2 stop");
        wcode = 1; stamp = 0; fcode = 1; smp = 4'b0110;
        do_start();
        run_bits(256 + 10, "R3/R4 pair width long frame");
    endtask

    task automatic t_iqsign();
        do_stop("R2 stop");
        wcode = 2; fcode = 0; dsen = 0; smp = 4'b1011;
        do_start();
        run_bits(130, "R4/R8 IQ sign no word pulse");
    endtask

    task automatic t_single();
        do_stop("R2 stop");
        wcode = 0; smp = 4'b0111;
        do_start();
        run_bits(130, "R4 single bit");
    endtask

    task automatic t_tsync_free();
        do_stop("R2 stop");
        tsall = 1;
        run_bits(2 * 128 + 3, "R9 free time pulse");
        tsall = 0;
        do_start();
        run_bits(10, "R9 restart after free run");
    endtask

    task automatic t_clear();
        stamp = 1; dsen = 1;
        crst = 1; @(posedge clk); #1 crst = 0;
        bpos = 0; bfnum = 0;
        @(negedge clk);
        check("R10 idle bit", {bclk, sdata, fsync, dsync, tsync}, 5'b0);
        run_bits(40, "R10 clear restarts at frame 0");
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_full_stamp();
        t_stop_resume();
        t_ipair_long();
        t_iqsign();
        t_single();
        t_tsync_free();
        t_clear();
        summary();
    end
endmodule